// File: doc/BRIEF.md
# Serial Link Low-Power Wake Controller

This block sits beside a byte-oriented controller for a single-wire serial bus and decides when that controller may sleep and how it wakes. A strobe from the processor's wait instruction and a depth-select bit move the block from run into one of two sleep levels. In light sleep the link core keeps its clock. In deep sleep the link core's clock enable is dropped, and this is the lowest-power level. In both sleep levels the transmit gate is closed so the node never drives the bus.

The bus input is synchronized and watched for a passive-to-active (rising) edge. The first such edge while asleep returns the block to run and raises a wake request that is held until acknowledged. A second output marks the request as non-maskable when it came from deep sleep. A third output reports whether the message that caused the wake will be received whole. This is always true from light sleep. From deep sleep it is true only if software read an end-of-frame status while in run after the last bus activity. The processor uses that flag to decide whether to trust or discard the first frame.

Top module: `linkwake_ctrl`

## Requirements
- R1: In run, with `tx_busy` low, a `wait_stb` pulse with `deep_sel` = 0 moves the block to light sleep on the next clock edge: `tx_en` low and `core_clk_en` high.
- R2: In run, with `tx_busy` low, a `wait_stb` pulse with `deep_sel` = 1 moves the block to deep sleep on the next clock edge: `tx_en` low and `core_clk_en` low.
- R3: `tx_en` is high exactly while the block is in run, and low in both sleep levels.
- R4: `core_clk_en` is low only in deep sleep.
- R5: In either sleep level, a rising edge on `bus_in` (low to high, with `BUS_ACTIVE_HIGH` = 1) returns the block to run and sets `wake_irq` at the clock edge `SYNC_STAGES` edges after the first edge that samples the new level. A falling edge does not wake the block.
- R6: A `wait_stb` pulse while `tx_busy` is high is ignored, and the block stays in run.
- R7: `wake_irq`, `wake_nmi` and `wake_clean` hold until `irq_ack` is high at a clock edge, which clears all three. A wake in the same cycle as an acknowledge takes priority. `wake_nmi` is 1 for a wake from deep sleep and 0 for a wake from light sleep.
- R8: A wake from light sleep sets `wake_clean` to 1.
- R9: A wake from deep sleep sets `wake_clean` to the end-of-frame-seen flag. The flag is set by `eof_rd` in run and cleared by any bus rising edge. If both happen in the same cycle, the set wins.
- R10: `eof_rd` is ignored while asleep. A bus rising edge in run after an `eof_rd` clears the flag, so a later deep-sleep wake reports `wake_clean` = 0.
- R11: While asleep, `wait_stb` and `deep_sel` have no effect: the sleep level and `core_clk_en` are unchanged. A rising bus edge in run raises no `wake_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_stb | input | 1 | One-cycle pulse: processor executed a wait instruction |
| deep_sel | input | 1 | Sleep depth select: 0 light, 1 deep |
| tx_busy | input | 1 | Link core is transmitting |
| eof_rd | input | 1 | Software read an end-of-frame status |
| bus_in | input | 1 | Asynchronous serial bus level |
| irq_ack | input | 1 | Processor acknowledge of the wake request |
| tx_en | output | 1 | Transmit gate to the link core |
| core_clk_en | output | 1 | Clock enable for the link core |
| wake_irq | output | 1 | Held wake interrupt request |
| wake_nmi | output | 1 | Wake request is of the non-maskable kind |
| wake_clean | output | 1 | The waking message will be received whole |

## Verification
The bench goes after the end-of-frame flag's lifetime. An eof read followed by bus activity before deep sleep must give an unclean wake. A design that kept the flag sticky would report a clean wake and mislead software. It also sends a sleep request during a transmission, where a design that ignored `tx_busy` would cut a frame off mid-bus. It checks that falling edges and wait pulses during sleep do nothing, since a design that woke on any edge or re-evaluated the depth bit while asleep would wake early or drop the clock in light sleep. It checks the exact wake latency through the synchronizer and an acknowledge arriving together with a wake, where a wrong priority would silently lose a wake request.

// File: rtl/lw_pkg.sv
package lw_pkg;
   typedef enum logic [1:0] {
      LW_RUN   = 2'd0,
      LW_LIGHT = 2'd1,
      LW_DEEP  = 2'd2
   } lw_state_e;
endpackage

// File: rtl/lw_bus_sync.sv
module lw_bus_sync #(
   parameter int SYNC_STAGES     = 2,
   parameter bit BUS_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   output logic bus_rise
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("lw_bus_sync: SYNC_STAGES must lie in 2..4");
   end

   logic             active_lvl;
   logic [LAST:0]    chain_q;
   logic             prev_q;

   // Polarity variant: map the bus level to an "active" level
   if (BUS_ACTIVE_HIGH) begin : g_pol_high
      assign active_lvl = bus_in;
   end else begin : g_pol_low
      assign active_lvl = ~bus_in;
   end

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= active_lvl;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[LAST];
   end

   assign bus_rise = chain_q[LAST] & ~prev_q;

   // R5: a detected edge is a single-cycle event
   p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rise |=> !bus_rise);
endmodule

// File: rtl/lw_mode_fsm.sv
module lw_mode_fsm
   import lw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wait_stb,
   input  logic      deep_sel,
   input  logic      tx_busy,
   input  logic      bus_rise,
   output lw_state_e state_q,
   output logic      wake_fire,
   output logic      wake_deep
);
   lw_state_e state_d;
   logic      sleep_ok;

   assign sleep_ok = wait_stb & ~tx_busy;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LW_RUN: begin
            if (sleep_ok) state_d = deep_sel ? LW_DEEP : LW_LIGHT;
         end
         LW_LIGHT, LW_DEEP: begin
            if (bus_rise) state_d = LW_RUN;
         end
         default: state_d = LW_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LW_RUN;
      else        state_q <= state_d;
   end

   assign wake_fire = (state_q != LW_RUN) & bus_rise;
   assign wake_deep = (state_q == LW_DEEP) & bus_rise;

   p_light_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LW_RUN && wait_stb && !tx_busy && !deep_sel) |=> state_q == LW_LIGHT);
   p_deep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LW_RUN && wait_stb && !tx_busy && deep_sel) |=> state_q == LW_DEEP);
   p_wake_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != LW_RUN && bus_rise) |=> state_q == LW_RUN);
   p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LW_RUN && tx_busy) |=> state_q == LW_RUN);
   p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != LW_RUN && !bus_rise) |=> state_q == $past(state_q));
endmodule

// File: rtl/lw_eof_track.sv
module lw_eof_track (
   input  logic clk,
   input  logic rst_n,
   input  logic in_run,
   input  logic eof_rd,
   input  logic bus_rise,
   output logic eof_seen
);
   logic set_ev;

   assign set_ev = in_run & eof_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        eof_seen <= 1'b0;
      else if (set_ev)   eof_seen <= 1'b1;
      else if (bus_rise) eof_seen <= 1'b0;
   end

   p_eof_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rise && !eof_rd) |=> !eof_seen);
   p_eof_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_run && !bus_rise) |=> $stable(eof_seen));
endmodule

// File: rtl/lw_wake_status.sv
module lw_wake_status (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_fire,
   input  logic wake_deep,
   input  logic eof_seen,
   input  logic irq_ack,
   output logic wake_irq,
   output logic wake_nmi,
   output logic wake_clean
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_irq   <= 1'b0;
         wake_nmi   <= 1'b0;
         wake_clean <= 1'b0;
      end else if (wake_fire) begin
         wake_irq   <= 1'b1;
         wake_nmi   <= wake_deep;
         wake_clean <= wake_deep ? eof_seen : 1'b1;
      end else if (irq_ack) begin
         wake_irq   <= 1'b0;
         wake_nmi   <= 1'b0;
         wake_clean <= 1'b0;
      end
   end

   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_irq && !irq_ack) |=> wake_irq);
   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !wake_fire) |=> (!wake_irq && !wake_nmi && !wake_clean));
   p_light_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_fire && !wake_deep) |=> (wake_clean && !wake_nmi));
   p_deep_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_deep |=> (wake_nmi && wake_clean == $past(eof_seen)));
endmodule

// File: rtl/linkwake_ctrl.sv
module linkwake_ctrl
   import lw_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter bit BUS_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_stb,
   input  logic deep_sel,
   input  logic tx_busy,
   input  logic eof_rd,
   input  logic bus_in,
   input  logic irq_ack,
   output logic tx_en,
   output logic core_clk_en,
   output logic wake_irq,
   output logic wake_nmi,
   output logic wake_clean
);
   lw_state_e state_q;
   logic      bus_rise;
   logic      wake_fire;
   logic      wake_deep;
   logic      eof_seen;

   lw_bus_sync #(
      .SYNC_STAGES     (SYNC_STAGES),
      .BUS_ACTIVE_HIGH (BUS_ACTIVE_HIGH)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_in   (bus_in),
      .bus_rise (bus_rise)
   );

   lw_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_stb  (wait_stb),
      .deep_sel  (deep_sel),
      .tx_busy   (tx_busy),
      .bus_rise  (bus_rise),
      .state_q   (state_q),
      .wake_fire (wake_fire),
      .wake_deep (wake_deep)
   );

   lw_eof_track u_eof (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_run   (state_q == LW_RUN),
      .eof_rd   (eof_rd),
      .bus_rise (bus_rise),
      .eof_seen (eof_seen)
   );

   lw_wake_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake_fire  (wake_fire),
      .wake_deep  (wake_deep),
      .eof_seen   (eof_seen),
      .irq_ack    (irq_ack),
      .wake_irq   (wake_irq),
      .wake_nmi   (wake_nmi),
      .wake_clean (wake_clean)
   );

   assign tx_en       = (state_q == LW_RUN);
   assign core_clk_en = (state_q != LW_DEEP);

   // R4: the core clock only drops on an accepted deep-sleep request
   p_clk_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_clk_en) |-> $past(wait_stb && deep_sel && !tx_busy));
   // R11: no wake request arises while the block was already running
   p_no_run_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_irq) |-> $past(!tx_en));
endmodule

// File: tb/linkwake_ctrl_tb.sv
module linkwake_ctrl_tb;
   localparam int NS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wait_stb = 0, deep_sel = 0, tx_busy = 0, eof_rd = 0, bus_in = 0, irq_ack = 0;
   logic tx_en, core_clk_en, wake_irq, wake_nmi, wake_clean;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   linkwake_ctrl #(.SYNC_STAGES(NS), .BUS_ACTIVE_HIGH(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wait_stb(wait_stb), .deep_sel(deep_sel),
      .tx_busy(tx_busy), .eof_rd(eof_rd), .bus_in(bus_in), .irq_ack(irq_ack),
      .tx_en(tx_en), .core_clk_en(core_clk_en), .wake_irq(wake_irq),
      .wake_nmi(wake_nmi), .wake_clean(wake_clean)
   );

   // Behavioural reference: mode 0 run, 1 light, 2 deep
   int m_mode = 0;
   bit m_eof = 0, m_irq = 0, m_nmi = 0, m_clean = 0, m_prev = 0;
   bit m_q[$];

   initial for (int i = 0; i < NS; i++) m_q.push_back(1'b0);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_eof = 0; m_irq = 0; m_nmi = 0; m_clean = 0; m_prev = 0;
         m_q.delete();
         for (int i = 0; i < NS; i++) m_q.push_back(1'b0);
      end else begin
         bit rise, woke;
         rise = m_q[NS-1] && !m_prev;
         woke = 0;
         if (m_mode == 0) begin
            if (rise) m_eof = 0;
            if (eof_rd) m_eof = 1;
            if (wait_stb && !tx_busy) m_mode = deep_sel ? 2 : 1;
         end else if (rise) begin
            woke = 1;
            m_irq = 1;
            m_nmi = (m_mode == 2);
            m_clean = (m_mode == 1) ? 1'b1 : m_eof;
            m_eof = 0;
            m_mode = 0;
         end
         if (irq_ack && !woke) begin m_irq = 0; m_nmi = 0; m_clean = 0; end
         m_prev = m_q[NS-1];
         m_q.push_front(bus_in);
         void'(m_q.pop_back());
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk("R3", "tx_en", tx_en, m_mode == 0);
         chk("R4", "core_clk_en", core_clk_en, m_mode != 2);
         chk("R5", "wake_irq", wake_irq, m_irq);
         chk("R7", "wake_nmi", wake_nmi, m_nmi);
         chk("R9", "wake_clean", wake_clean, m_clean);
      end
   end

   task automatic tick(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_wait(bit deep);
      deep_sel = deep; wait_stb = 1; tick(1); wait_stb = 0;
   endtask

   task automatic ack();
      irq_ack = 1; tick(1); irq_ack = 0;
   endtask

   task automatic bus_pulse();
      bus_in = 1; tick(4); bus_in = 0; tick(4);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      tick(3);
      chk("R3", "reset tx_en", tx_en, 1);
      chk("R4", "reset clk_en", core_clk_en, 1);
      chk("R7", "reset irq", wake_irq, 0);
      rst_n = 1; tick(2);

      // Light sleep entry and wake
      pulse_wait(0);
      chk("R1", "light tx_en", tx_en, 0);
      chk("R1", "light clk_en", core_clk_en, 1);
      bus_in = 1; tick(NS + 1);
      chk("R5", "irq after sync latency", wake_irq, 1);
      chk("R8", "light clean", wake_clean, 1);
      tick(4); bus_in = 0; tick(4);
      chk("R7", "irq held", wake_irq, 1);
      ack();
      chk("R7", "ack clears irq", wake_irq, 0);

      // Deep sleep after eof read: clean wake, non-maskable
      eof_rd = 1; tick(1); eof_rd = 0;
      pulse_wait(1);
      chk("R2", "deep clk_en", core_clk_en, 0);
      chk("R2", "deep tx_en", tx_en, 0);
      bus_pulse();
      chk("R9", "deep clean with eof", wake_clean, 1);
      chk("R7", "deep nmi", wake_nmi, 1);
      ack();

      // Deep sleep without eof read
      pulse_wait(1);
      bus_pulse();
      chk("R9", "deep clean without eof", wake_clean, 0);
      ack();

      // Eof read then bus activity in run before deep sleep
      eof_rd = 1; tick(1); eof_rd = 0;
      bus_pulse();
      chk("R11", "run edge no irq", wake_irq, 0);
      pulse_wait(1);
      eof_rd = 1; tick(1); eof_rd = 0;   // ignored while asleep
      bus_pulse();
      chk("R10", "stale eof cleared", wake_clean, 0);
      ack();

      // Busy blocks sleep
      tx_busy = 1; pulse_wait(1); tx_busy = 0;
      chk("R6", "busy keeps run", tx_en, 1);
      chk("R6", "busy keeps clock", core_clk_en, 1);

      // Wait/deep_sel during light sleep, falling edge no wake
      bus_in = 1; tick(6);
      pulse_wait(0);
      pulse_wait(1);
      chk("R11", "clk_en kept in light", core_clk_en, 1);
      bus_in = 0; tick(6);
      chk("R5", "falling edge no wake", tx_en, 0);

      // Wake coinciding with an acknowledge of a prior request
      bus_in = 1; tick(NS + 1); bus_in = 0;
      tick(4);
      pulse_wait(1);
      bus_in = 1; tick(NS);
      irq_ack = 1; tick(1); irq_ack = 0;
      chk("R7", "wake beats ack", wake_irq, 1);
      chk("R7", "nmi after coincident ack", wake_nmi, 1);
      tick(3); bus_in = 0; tick(3);
      ack();

      finish_run();
   end

   initial begin
      wait (cyc > 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      finish_run();
   end
endmodule